// File: doc/BRIEF.md
# Identification Window with Bit-Serial Register Readback

This block sits in the save-RAM read/write path of a cartridge controller. When the identification mode input is low, every save-RAM access goes straight through: the memory strobes follow the host strobes and read data comes from the external memory. When identification mode is high, the block takes over the whole save-RAM space. The external memory strobes are held low, and reads are answered from an internal window.

The window holds a five-byte signature, two voltage codes and six 16-bit internal registers: two control words, an I/O status word, the save-RAM device ID, the flash bank and the save-RAM bank. Each register takes sixteen consecutive byte addresses, and each address returns one bit in data bit 0. The window also holds a 1 KB scratch cache that can be read and written one byte at a time. The voltage codes and the register contents come in as inputs. The block only presents them.

Every read returns its byte on `rdata_o` one clock after the read strobe, with `rvalid_o` high in that cycle.

Top module: `idw_window`

## Requirements
- R1: After reset, `rdata_o` is 0x00 and `rvalid_o` is low.
- R2: In identification mode, a read of window offset 0, 1, 2, 3 or 4 returns 0x34, 0x16, 0x96, 0x24 or 0xF6 respectively.
- R3: In identification mode, offset 5 returns the battery voltage code `vbat_i` and offset 6 returns the supply code `vsup_i`, zero-extended to a byte (range 0 to 63).
- R4: In identification mode, offset 0x8070+n (n = 0..15) returns bit n of `ctl0_i` in data bit 0.
- R5: In identification mode, offset 0x8040+n returns bit n of `ctl1_i` and offset 0x8080+n returns bit n of `iost_i`, in data bit 0.
- R6: In identification mode, offsets 0x8050+n, 0x8090+n and 0x80A0+n return bit n of `devid_i`, `fbank_i` and `sbank_i` respectively, in data bit 0.
- R7: In every bit-serial read, data bits 7 to 1 are zero.
- R8: In identification mode, a byte written to offset 0xC000+k (k = 0..1023) is returned by any later read of the same offset.
- R9: In identification mode, reads of offsets that are not mapped return 0x00, and writes to them change no window content.
- R10: When identification mode is low, `mem_rd_o` and `mem_wr_o` follow `rd_en_i` and `wr_en_i`, a read returns the `mem_rdata_i` value seen with the strobe, and writes leave the cache unchanged.
- R11: When identification mode is high, `mem_rd_o` and `mem_wr_o` stay low.
- R12: `rvalid_o` is high in exactly the cycle after each cycle with `rd_en_i` high, and `rdata_o` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_mode_i | input | 1 | Identification mode enable |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 16 | Byte offset in save-RAM space |
| wdata_i | input | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from external save RAM |
| ctl0_i | input | 16 | First control register |
| ctl1_i | input | 16 | Second control register |
| iost_i | input | 16 | I/O status register |
| devid_i | input | 16 | Save-RAM device ID |
| fbank_i | input | 16 | Flash bank register |
| sbank_i | input | 16 | Save-RAM bank register |
| vbat_i | input | 6 | Battery voltage code |
| vsup_i | input | 6 | Supply voltage code |
| mem_rd_o | output | 1 | Read strobe to external save RAM |
| mem_wr_o | output | 1 | Write strobe to external save RAM |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |

## Verification
A wrong region decode shows on the first read of the affected offset. It returns a neighbour's byte, or a nonzero byte where 0x00 is due, one cycle after the strobe. A wrong bit index in the serial path mixes up bit n across a register's sixteen reads, so registers are given asymmetric patterns. A write that reaches the cache when it should not stays hidden until that cache byte is read back. For that reason each ignored or bypassed write is followed by a read of the byte it could have changed. A strobe leak to external memory shows in the same cycle on `mem_rd_o` or `mem_wr_o`.

// File: rtl/idw_pkg.sv
package idw_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_SIG, RG_VBAT, RG_VSUP,
    RG_CTL0, RG_CTL1, RG_IOST, RG_DEVID, RG_FBANK, RG_SBANK,
    RG_CACHE
  } rgn_e;

  localparam int SIG_LEN = 5;
  localparam int NREG    = 6;

  function automatic logic [7:0] sig_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h34;
      3'd1:    return 8'h16;
      3'd2:    return 8'h96;
      3'd3:    return 8'h24;
      3'd4:    return 8'hF6;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/idw_decode.sv
module idw_decode
  import idw_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 16,
  parameter int CACHE_AW = 10,
  parameter logic [ADDR_W-1:0] CACHE_BASE = 'hC000
) (
  input  logic [ADDR_W-1:0]        addr_i,
  output rgn_e                     rgn_o,
  output logic [$clog2(REG_W)-1:0] bit_o
);
  localparam int BIT_W = $clog2(REG_W);
  localparam logic [ADDR_W-1:0] P_CTL1  = 'h8040;
  localparam logic [ADDR_W-1:0] P_DEVID = 'h8050;
  localparam logic [ADDR_W-1:0] P_CTL0  = 'h8070;
  localparam logic [ADDR_W-1:0] P_IOST  = 'h8080;
  localparam logic [ADDR_W-1:0] P_FBANK = 'h8090;
  localparam logic [ADDR_W-1:0] P_SBANK = 'h80A0;

  logic [ADDR_W-BIT_W-1:0] page;
  assign page  = addr_i[ADDR_W-1:BIT_W];
  assign bit_o = addr_i[BIT_W-1:0];

  always_comb begin
    rgn_o = RG_NONE;
    if (addr_i < ADDR_W'(SIG_LEN))                                  rgn_o = RG_SIG;
    else if (addr_i == ADDR_W'(SIG_LEN))                            rgn_o = RG_VBAT;
    else if (addr_i == ADDR_W'(SIG_LEN + 1))                        rgn_o = RG_VSUP;
    else if (page == P_CTL0[ADDR_W-1:BIT_W])                        rgn_o = RG_CTL0;
    else if (page == P_CTL1[ADDR_W-1:BIT_W])                        rgn_o = RG_CTL1;
    else if (page == P_IOST[ADDR_W-1:BIT_W])                        rgn_o = RG_IOST;
    else if (page == P_DEVID[ADDR_W-1:BIT_W])                       rgn_o = RG_DEVID;
    else if (page == P_FBANK[ADDR_W-1:BIT_W])                       rgn_o = RG_FBANK;
    else if (page == P_SBANK[ADDR_W-1:BIT_W])                       rgn_o = RG_SBANK;
    else if (addr_i[ADDR_W-1:CACHE_AW] == CACHE_BASE[ADDR_W-1:CACHE_AW]) rgn_o = RG_CACHE;
  end

endmodule

// File: rtl/idw_bitsel.sv
module idw_bitsel #(
  parameter int NREG  = 6,
  parameter int REG_W = 16
) (
  input  logic [NREG-1:0][REG_W-1:0]  regs_i,
  input  logic [$clog2(NREG)-1:0]     sel_i,
  input  logic [$clog2(REG_W)-1:0]    bit_i,
  output logic                        bit_o
);
  logic [NREG-1:0] picked;

  for (genvar g = 0; g < NREG; g++) begin : g_pick
    assign picked[g] = regs_i[g][bit_i];
  end

  assign bit_o = (int'(sel_i) < NREG) ? picked[sel_i] : 1'b0;

endmodule

// File: rtl/idw_cache.sv
module idw_cache #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/idw_window.sv
module idw_window
  import idw_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 16,
  parameter int VOLT_W   = 6,
  parameter int CACHE_AW = 10,
  parameter logic [ADDR_W-1:0] CACHE_BASE = 'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_mode_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [REG_W-1:0]  ctl0_i,
  input  logic [REG_W-1:0]  ctl1_i,
  input  logic [REG_W-1:0]  iost_i,
  input  logic [REG_W-1:0]  devid_i,
  input  logic [REG_W-1:0]  fbank_i,
  input  logic [REG_W-1:0]  sbank_i,
  input  logic [VOLT_W-1:0] vbat_i,
  input  logic [VOLT_W-1:0] vsup_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);
  localparam int DW    = 8;
  localparam int BIT_W = $clog2(REG_W);
  localparam int SEL_W = $clog2(NREG);

  rgn_e              rgn;
  logic [BIT_W-1:0]  bit_idx;
  logic [SEL_W-1:0]  reg_sel;
  logic              ser_bit;
  logic [DW-1:0]     cache_rd;
  logic [DW-1:0]     win_val;
  logic              cache_we;
  logic [NREG-1:0][REG_W-1:0] regs;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q;

  idw_decode #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CACHE_AW(CACHE_AW), .CACHE_BASE(CACHE_BASE)
  ) i_decode (
    .addr_i(addr_i), .rgn_o(rgn), .bit_o(bit_idx)
  );

  assign regs = {sbank_i, fbank_i, devid_i, iost_i, ctl1_i, ctl0_i};

  always_comb begin
    unique case (rgn)
      RG_CTL1:  reg_sel = SEL_W'(1);
      RG_IOST:  reg_sel = SEL_W'(2);
      RG_DEVID: reg_sel = SEL_W'(3);
      RG_FBANK: reg_sel = SEL_W'(4);
      RG_SBANK: reg_sel = SEL_W'(5);
      default:  reg_sel = SEL_W'(0);
    endcase
  end

  idw_bitsel #(.NREG(NREG), .REG_W(REG_W)) i_bitsel (
    .regs_i(regs), .sel_i(reg_sel), .bit_i(bit_idx), .bit_o(ser_bit)
  );

  assign cache_we = id_mode_i && wr_en_i && (rgn == RG_CACHE);

  idw_cache #(.AW(CACHE_AW), .DW(DW)) i_cache (
    .clk_i(clk_i), .we_i(cache_we), .addr_i(addr_i[CACHE_AW-1:0]),
    .wdata_i(wdata_i), .rdata_o(cache_rd)
  );

  always_comb begin
    unique case (rgn)
      RG_SIG:   win_val = sig_byte(addr_i[2:0]);
      RG_VBAT:  win_val = DW'(vbat_i);
      RG_VSUP:  win_val = DW'(vsup_i);
      RG_CTL0, RG_CTL1, RG_IOST, RG_DEVID, RG_FBANK, RG_SBANK:
                win_val = {{(DW-1){1'b0}}, ser_bit};
      RG_CACHE: win_val = cache_rd;
      default:  win_val = '0;
    endcase
  end

  // external memory is fenced off while the window is open
  assign mem_rd_o = rd_en_i && !id_mode_i;
  assign mem_wr_o = wr_en_i && !id_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= id_mode_i ? win_val : mem_rdata_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/idw_window_chk.sv
module idw_window_chk #(
  parameter int ADDR_W = 16,
  parameter int VOLT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              id_mode_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        mem_rdata_i,
  input logic [VOLT_W-1:0] vbat_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [7:0]        rdata_o,
  input logic              rvalid_o
);

  // R11
  fenced_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_mode_i |-> (!mem_rd_o && !mem_wr_o));

  // R12
  valid_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);

  // R12
  hold_without_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rvalid_o && $stable(rdata_o)));

  // R2
  sig_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_i && rd_en_i && addr_i == '0) |=> rdata_o == 8'h34);

  // R3
  vbat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_i && rd_en_i && addr_i == ADDR_W'(5)) |=> rdata_o == 8'($past(vbat_i)));

  // R7
  serial_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_i && rd_en_i && addr_i[ADDR_W-1:8] == 8'h80) |=> rdata_o[7:1] == 7'd0);

  // R10
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_mode_i && rd_en_i) |=> rdata_o == $past(mem_rdata_i));

endmodule

bind idw_window idw_window_chk #(.ADDR_W(ADDR_W), .VOLT_W(VOLT_W)) i_chk (.*);

// File: tb/test_idw_window.sv
`timescale 1ns/1ps
module test_idw_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_mode, rd_en, wr_en;
  logic [15:0] addr;
  logic [7:0]  wdata, mem_rdata;
  logic [15:0] ctl0, ctl1, iost, devid, fbank, sbank;
  logic [5:0]  vbat, vsup;
  logic        mem_rd, mem_wr;
  logic [7:0]  rdata;
  logic        rvalid;

  typedef struct { string tag; logic [7:0] exp; } exp_t;
  exp_t sbq[$];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  idw_window i_idw_window (
    .clk_i(clk), .rst_ni(rst_n), .id_mode_i(id_mode), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .mem_rdata_i(mem_rdata),
    .ctl0_i(ctl0), .ctl1_i(ctl1), .iost_i(iost), .devid_i(devid),
    .fbank_i(fbank), .sbank_i(sbank), .vbat_i(vbat), .vsup_i(vsup),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    rd_en = 1'b1; addr = a;
    it.tag = tag; it.exp = e;
    sbq.push_back(it);
    #1 chk(id_mode ? "R11 mem_rd" : "R10 mem_rd", {15'd0, mem_rd}, {15'd0, !id_mode});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    #1 chk(id_mode ? "R11 mem_wr" : "R10 mem_wr", {15'd0, mem_wr}, {15'd0, !id_mode});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && rvalid) begin
      if (sbq.size() == 0) chk("R12 unexpected rvalid", 16'd1, 16'd0);
      else begin
        e = sbq.pop_front();
        chk(e.tag, {8'd0, rdata}, {8'd0, e.exp});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [7:0] sig [5] = '{8'h34, 8'h16, 8'h96, 8'h24, 8'hF6};

  initial begin
    rst_n = 1'b0; id_mode = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; mem_rdata = '0;
    ctl0 = 16'hA5C3; ctl1 = 16'h0630; iost = 16'hFFFF;
    devid = 16'h1E2D; fbank = 16'h8001; sbank = 16'h7FFE;
    vbat = 6'd63; vsup = 6'd17;
    repeat (3) @(negedge clk);
    chk("R1 rdata", {8'd0, rdata}, 16'h0000);
    chk("R1 rvalid", {15'd0, rvalid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    id_mode = 1'b1;

    for (int i = 0; i < 5; i++) rd(16'(i), sig[i], "R2 signature");
    rd(16'd5, {2'b0, vbat}, "R3 battery");
    rd(16'd6, {2'b0, vsup}, "R3 supply");
    vbat = 6'd0;
    rd(16'd5, 8'h00, "R3 battery low");

    for (int n = 0; n < 16; n++) rd(16'h8070 + 16'(n), {7'd0, ctl0[n]}, "R4 ctl0");
    for (int n = 0; n < 16; n++) rd(16'h8040 + 16'(n), {7'd0, ctl1[n]}, "R5 ctl1");
    for (int n = 0; n < 16; n++) rd(16'h8080 + 16'(n), 8'h01, "R5 R7 iost");
    for (int n = 0; n < 16; n++) rd(16'h8050 + 16'(n), {7'd0, devid[n]}, "R6 devid");
    for (int n = 0; n < 16; n++) rd(16'h8090 + 16'(n), {7'd0, fbank[n]}, "R6 fbank");
    for (int n = 0; n < 16; n++) rd(16'h80A0 + 16'(n), {7'd0, sbank[n]}, "R6 sbank");

    wr(16'hC000, 8'h5A);
    wr(16'hC3FF, 8'hA5);
    wr(16'hC155, 8'h3C);
    rd(16'hC000, 8'h5A, "R8 cache first");
    rd(16'hC3FF, 8'hA5, "R8 cache last");
    rd(16'hC155, 8'h3C, "R8 cache mid");
    wr(16'hC155, 8'hC3);
    rd(16'hC155, 8'hC3, "R8 cache overwrite");

    rd(16'h0007, 8'h00, "R9 unmapped low");
    rd(16'h8060, 8'h00, "R9 unmapped gap");
    rd(16'h80B0, 8'h00, "R9 unmapped above banks");
    rd(16'hFFFF, 8'h00, "R9 unmapped top");
    wr(16'hC400, 8'h77);
    wr(16'h0000, 8'hEE);
    rd(16'hC400, 8'h00, "R9 ignored write");
    rd(16'h0000, 8'h34, "R9 signature after write");
    rd(16'hC000, 8'h5A, "R9 cache untouched");

    id_mode = 1'b0;
    mem_rdata = 8'hC7;
    rd(16'h0005, 8'hC7, "R10 pass-through");
    mem_rdata = 8'h0B;
    rd(16'hC000, 8'h0B, "R10 pass-through cache addr");
    wr(16'hC000, 8'h11);
    id_mode = 1'b1;
    rd(16'hC000, 8'h5A, "R10 cache not written");

    repeat (4) @(negedge clk);
    chk("R12 all reads answered", 16'(sbq.size()), 16'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule